// File: doc/BRIEF.md
# Core Supply Step-Down Sequencer

After power-up this block settles the core supply level from a verified voltage-identification bit and enables the power-hungry clock regions in a safe order. The supply begins at the nominal high level. When the identification result arrives, the block takes the read bit, or a value forced through a two-switch emulation override, and decides whether a single downward step to the reduced level is allowed. If it is, the block issues one level request and waits for the supply controller's settled acknowledge. If the identification read failed, or the effective bit is 0, the supply stays at the nominal level for good, and the gated clocks open after a settle delay.

The step is made once and in one direction only. After the decision, later identification inputs have no effect. If the acknowledge does not arrive within a parameterised number of cycles, the block raises a sticky fault, requests the nominal level again, waits the settle delay and then opens the clocks. The protocol used to program the external supply lies outside this block.

States: `ST_IDLE` (wait for an identification result), `ST_REQ_LOW` (strobe a request for the reduced level), `ST_WAIT_ACK` (count cycles until the acknowledge arrives), `ST_FALLBACK` (strobe a request for the nominal level and flag the fault), `ST_SETTLE` (count the settle delay at nominal), `ST_RUN_NOM` and `ST_RUN_LOW` (terminal, clocks enabled). Transitions: IDLE→REQ_LOW when the result is valid, error-free and effectively 1. IDLE→SETTLE when the result is valid but in error or effectively 0. REQ_LOW→WAIT_ACK always. WAIT_ACK→RUN_LOW on acknowledge. WAIT_ACK→FALLBACK when the timeout expires. FALLBACK→SETTLE always. SETTLE→RUN_NOM when the delay has elapsed.

Top module: `vstep_seq`

## Requirements
- R1: During reset, and afterwards until `id_valid` is seen, `sel_low`, `req_stb`, `clk_en` and `fault` are all 0.
- R2: The effective bit is taken from `ovr_sw` as follows: 2'b01 forces 0, 2'b10 forces 1, and 2'b00 and 2'b11 pass `id_bit` through. It is sampled at the clock edge where `id_valid` is first seen high.
- R3: If `id_err` is high with `id_valid`, the level stays nominal whatever the override or bit, no request is strobed, and `clk_en` rises after SETTLE_CYC cycles.
- R4: An effective bit of 0 gives no request, `sel_low` stays 0, and `clk_en` rises SETTLE_CYC cycles after the deciding edge.
- R5: An effective bit of 1 sets `sel_low` to 1 in the cycle after the deciding edge, with a `req_stb` pulse exactly one cycle long.
- R6: A `sup_ack` sampled on any of the ACK_TO edges after the request cycle moves the block to the reduced-level run state. `clk_en` rises in the next cycle and `sel_low` stays 1.
- R7: If no acknowledge arrives within ACK_TO edges, the next cycle shows `req_stb`=1 with `sel_low`=0, and `fault` rises and stays 1.
- R8: After the fallback request, `clk_en` rises SETTLE_CYC+1 cycles later.
- R9: Once decided, changes on `id_valid`, `id_err`, `id_bit` and `ovr_sw` have no effect. A `sup_ack` outside the wait state is ignored. `sel_low` never returns to 1 after it has dropped.
- R10: `clk_en` stays 0 until the level is established and then stays 1. `req_stb` is never high while `clk_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_valid | input | 1 | Identification result available |
| id_err | input | 1 | Identification read failed verification |
| id_bit | input | 1 | Verified identification bit |
| ovr_sw | input | 2 | Emulation override switches |
| sup_ack | input | 1 | Supply controller reports level settled |
| sel_low | output | 1 | Requested level: 1 reduced, 0 nominal |
| req_stb | output | 1 | One-cycle level request strobe |
| clk_en | output | 1 | Enable for high-power clock regions |
| fault | output | 1 | Sticky acknowledge-timeout flag |

## Verification
The hardest path to reach is the timeout fallback, together with the edges just around it: an acknowledge on the last allowed edge, and one a single edge too late that arrives during the fallback and must be ignored. The bench uses small ACK_TO and SETTLE_CYC values and sweeps every error, bit and override combination. For effective-1 cases it drives the acknowledge at several offsets, including never. For each cycle it computes the expected outputs from those offsets. In every case it also flips the identification inputs right after the decision, to show they are ignored.

// File: rtl/vstep_pkg.sv
package vstep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SETTLE   = 3'd1,
        ST_REQ_LOW  = 3'd2,
        ST_WAIT_ACK = 3'd3,
        ST_FALLBACK = 3'd4,
        ST_RUN_NOM  = 3'd5,
        ST_RUN_LOW  = 3'd6
    } vstep_st_e;

    localparam logic [1:0] OVR_FORCE0 = 2'b01;
    localparam logic [1:0] OVR_FORCE1 = 2'b10;
endpackage

// File: rtl/vstep_decode.sv
module vstep_decode
    import vstep_pkg::*;
(
    input  logic       id_valid,
    input  logic       id_err,
    input  logic       id_bit,
    input  logic [1:0] ovr_sw,
    output logic       go,
    output logic       want_low
);
    logic pick;

    always_comb begin
        unique case (ovr_sw)
            OVR_FORCE0: pick = 1'b0;
            OVR_FORCE1: pick = 1'b1;
            default:    pick = id_bit;
        endcase
        go       = id_valid;
        want_low = id_valid && !id_err && pick;
    end
endmodule

// File: rtl/vstep_cnt.sv
module vstep_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && cnt == {W{1'b1}}) |-> 1'b0) else $error("counter wrap"); // R7
endmodule

// File: rtl/vstep_seq.sv
module vstep_seq
    import vstep_pkg::*;
#(
    parameter int ACK_TO     = 100000,
    parameter int SETTLE_CYC = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       id_valid,
    input  logic       id_err,
    input  logic       id_bit,
    input  logic [1:0] ovr_sw,
    input  logic       sup_ack,
    output logic       sel_low,
    output logic       req_stb,
    output logic       clk_en,
    output logic       fault
);
    localparam int MAXC = (ACK_TO > SETTLE_CYC) ? ACK_TO : SETTLE_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] ACK_LAST = CW'(ACK_TO - 1);
    localparam logic [CW-1:0] SET_LAST = CW'(SETTLE_CYC - 1);

    vstep_st_e     st_q, st_d;
    logic          fault_q;
    logic          go, want_low;
    logic [CW-1:0] cnt;
    logic          cnt_clr, cnt_inc;

    vstep_decode u_dec (
        .id_valid (id_valid),
        .id_err   (id_err),
        .id_bit   (id_bit),
        .ovr_sw   (ovr_sw),
        .go       (go),
        .want_low (want_low)
    );

    assign cnt_clr = (st_d != st_q);
    assign cnt_inc = (st_q == ST_SETTLE) || (st_q == ST_WAIT_ACK);

    vstep_cnt #(.W(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:     if (go) st_d = want_low ? ST_REQ_LOW : ST_SETTLE;
            ST_SETTLE:   if (cnt == SET_LAST) st_d = ST_RUN_NOM;
            ST_REQ_LOW:  st_d = ST_WAIT_ACK;
            ST_WAIT_ACK: begin
                if (sup_ack)               st_d = ST_RUN_LOW;
                else if (cnt == ACK_LAST)  st_d = ST_FALLBACK;
            end
            ST_FALLBACK: st_d = ST_SETTLE;
            ST_RUN_NOM:  st_d = ST_RUN_NOM;
            ST_RUN_LOW:  st_d = ST_RUN_LOW;
            default:     st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            fault_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_WAIT_ACK && st_d == ST_FALLBACK) fault_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        sel_low = 1'b0;
        req_stb = 1'b0;
        clk_en  = 1'b0;
        unique case (st_q)
            ST_REQ_LOW:  begin sel_low = 1'b1; req_stb = 1'b1; end
            ST_WAIT_ACK: sel_low = 1'b1;
            ST_FALLBACK: req_stb = 1'b1;
            ST_RUN_NOM:  clk_en = 1'b1;
            ST_RUN_LOW:  begin sel_low = 1'b1; clk_en = 1'b1; end
            default:     ;
        endcase
        fault = fault_q;
    end

    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_stb |=> !req_stb) else $error("strobe longer than one cycle"); // R5
    AST_LOW_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_low) |-> req_stb) else $error("level change without strobe"); // R5
    AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |=> clk_en) else $error("clock enable dropped"); // R10
    AST_EN_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> !req_stb) else $error("request after enable"); // R10
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault) else $error("fault cleared"); // R7
    AST_NO_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_low && (clk_en || fault)) |=> !sel_low) else $error("reduced level after nominal commit"); // R9
    AST_TIMEOUT_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_ACK && !sup_ack && cnt == ACK_LAST) |=> (req_stb && !sel_low && fault))
        else $error("timeout without fallback"); // R7
endmodule

// File: tb/tb_vstep_seq.sv
`timescale 1ns/1ps
module tb_vstep_seq;
    localparam int T = 6;
    localparam int S = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       id_valid = 1'b0, id_err = 1'b0, id_bit = 1'b0, sup_ack = 1'b0;
    logic [1:0] ovr_sw = 2'b00;
    logic       sel_low, req_stb, clk_en, fault;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    vstep_seq #(.ACK_TO(T), .SETTLE_CYC(S)) dut (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_err(id_err),
        .id_bit(id_bit), .ovr_sw(ovr_sw), .sup_ack(sup_ack),
        .sel_low(sel_low), .req_stb(req_stb), .clk_en(clk_en), .fault(fault)
    );

    task automatic chk(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic run_case(input logic e, input logic b, input logic [1:0] sw, input int k);
        logic eff;
        logic esel, estb, een, eflt;
        string tg;
        eff = e ? 1'b0 : (sw == 2'b01) ? 1'b0 : (sw == 2'b10) ? 1'b1 : b;
        rst_n = 1'b0; id_valid = 0; id_err = 0; id_bit = 0; ovr_sw = 0; sup_ack = 0;
        repeat (2) @(negedge clk);
        chk("R1", "sel_low in reset", sel_low, 1'b0);
        chk("R1", "clk_en in reset", clk_en, 1'b0);
        chk("R1", "req_stb in reset", req_stb, 1'b0);
        chk("R1", "fault in reset", fault, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "clk_en before id", clk_en, 1'b0);
        chk("R1", "sel_low before id", sel_low, 1'b0);
        id_valid = 1'b1; id_err = e; id_bit = b; ovr_sw = sw;
        @(negedge clk);
        chk("R2", "sel_low after decision", sel_low, eff);
        for (int n = 0; n <= T + S + 6; n++) begin
            if (!eff) begin
                esel = 0; estb = 0; een = (n >= S); eflt = 0;
                tg = e ? "R3" : "R4";
            end else if (k >= 1 && k <= T) begin
                esel = 1; estb = (n == 0); een = (n > k); eflt = 0;
                tg = (n == 0) ? "R5" : (n > k) ? "R6" : "R10";
            end else begin
                esel = (n <= T); estb = (n == 0 || n == T + 1);
                eflt = (n >= T + 1); een = (n >= T + 2 + S);
                tg = (n <= T + 1) ? "R7" : "R8";
            end
            chk(tg, "sel_low", sel_low, esel);
            chk(tg, "req_stb", req_stb, estb);
            chk(tg, "clk_en", clk_en, een);
            chk(tg, "fault", fault, eflt);
            if (n == 0) begin
                id_err = ~e; id_bit = ~b; ovr_sw = ~sw;   // R9: ignored after decision
            end
            sup_ack = (k != 0) && (n >= k);
            @(negedge clk);
        end
        chk("R9", "sel_low final", sel_low, eff && k >= 1 && k <= T);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int e = 0; e < 2; e++)
            for (int b = 0; b < 2; b++)
                for (int sw = 0; sw < 4; sw++) begin
                    logic eff;
                    eff = (e != 0) ? 1'b0 : (sw == 1) ? 1'b0 : (sw == 2) ? 1'b1 : b[0];
                    if (eff) begin
                        run_case(e[0], b[0], sw[1:0], 1);
                        run_case(e[0], b[0], sw[1:0], 3);
                        run_case(e[0], b[0], sw[1:0], T);
                        run_case(e[0], b[0], sw[1:0], T + 1);
                        run_case(e[0], b[0], sw[1:0], 0);
                    end else begin
                        run_case(e[0], b[0], sw[1:0], 1);
                    end
                end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule